// File: doc/BRIEF.md
# Interrupt Event Aggregator

This block merges up to 32 asynchronous interrupt request lines, coming from peripheral and DMA sources, into one sticky processor request. Each line is synchronised to the system clock. Its current state is kept in a levels register. Reports on a line are captured in an events register, and an enable register picks which events may raise the processor request. Bit 31 of the enable register also selects the capture mode: in edge mode only a 0-to-1 change is recorded; in change mode every change is recorded.

Software reaches the block through a simple 32-bit register port. A write-only acknowledge register removes recorded events. All data crosses the port byte-reversed: the block holds each word in the opposite byte order to the port.

The processor request comes from a latch. The latch sets as soon as the enabled events become nonzero. It drops only when software writes the acknowledge register and no enabled event is then left. Reducing the enable register never drops the request.

A parameter gives the source map, which sets the line positions that carry real sources. By default these are bits 0 to 9 without bit 3 for DMA sources, and bits 12 to 28 for device sources.

Top module: `irq_aggregator`

## Requirements
- R1: The levels register (offset 0x2C) shows each enabled line's synchronised state. A change on `irq_lines_i` is visible in levels, and reported, after the third rising clock edge following the change.
- R2: With enable bit 31 clear (edge mode), a line going 0 to 1 sets its event bit, a line going 1 to 0 clears it, and no event bit is set without its line rising.
- R3: With enable bit 31 set (change mode), every change on a line, rising or falling, sets its event bit.
- R4: A write to the acknowledge register (offset 0x28) that is not a clear-all clears the event bits set in the stored-order data. It never alters event bit 31.
- R5: An acknowledge write in change mode whose stored-order data has bit 31 set (port bit 7) clears every event bit.
- R6: The processor request `cpu_irq_o` is set in the cycle after a line report or an enable write (offset 0x24) leaves events AND enable nonzero. It is never low while events AND enable is nonzero.
- R7: `cpu_irq_o` is cleared only by an acknowledge write after which events AND enable is zero. Enable writes and line falls never clear it.
- R8: The port data is the byte-reversed stored word: port bits 7:0 hold stored bits 31:24, and so on. A read returns the addressed register's value at the request edge, in port order, one cycle after the request. A read of the enable register returns the word that was written.
- R9: Writes to the levels register change nothing. Reads of the acknowledge register and of any offset other than 0x20, 0x24 and 0x2C return 0.
- R10: Line positions outside the source-map parameter read 0 in levels and never record events.
- R11: An acknowledge in the same cycle as a line report wins for the bits it names. Capture and clear-all use the mode that was held before any enable write in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines_i | input | 32 | Asynchronous interrupt request lines, one per source |
| bus_valid_i | input | 1 | Register access request in this cycle |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data in port byte order |
| bus_rdata_o | output | 32 | Read data in port byte order, valid one cycle after a read request |
| cpu_irq_o | output | 1 | Sticky processor interrupt request |

## Verification
The block is tried with single lines rising and falling in edge mode and then in change mode. This separates rise-only capture from any-change capture, and shows that a fall removes an event in edge mode but records one in change mode. Acknowledge writes are tried with named bits, with clear-all data in both modes, and with bit 31 pending. These separate clear-all from named clears and show that bit 31 is protected. Activity on disabled line positions, writes to the levels register, and acknowledge writes in the same cycle as a report each check one specific corner. A long pseudo-random stretch of line toggles mixed with enable and acknowledge traffic then compares the request line and every read against the reference model cycle by cycle.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
   localparam int DATA_W = 32;

   function automatic logic [DATA_W-1:0] byte_flip(input logic [DATA_W-1:0] w);
      logic [DATA_W-1:0] r;
      for (int b = 0; b < DATA_W / 8; b++) begin
         r[b*8 +: 8] = w[(DATA_W/8 - 1 - b)*8 +: 8];
      end
      return r;
   endfunction
endpackage

// File: rtl/irq_line_sync.sv
module irq_line_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] async_i,
   output logic [W-1:0] sync_o
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign sync_o = async_i;
      end else begin : g_chain
         logic [W-1:0] stage_q [STAGES];
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
            end else begin
               stage_q[0] <= async_i;
               for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
            end
         end
         assign sync_o = stage_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/irq_event_core.sv
module irq_event_core #(
   parameter int          W          = 32,
   parameter logic [31:0] SRC_MAP    = 32'h1FFF_F3F7,
   parameter int          MODE_BIT   = 31,
   parameter int          CLRALL_BIT = 31,
   parameter int          GUARD_BIT  = 31
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lines_sync_i,
   input  logic         en_wr_i,
   input  logic         ack_wr_i,
   input  logic [W-1:0] wdata_st_i,
   output logic [W-1:0] events_o,
   output logic [W-1:0] enable_o,
   output logic [W-1:0] levels_o,
   output logic         mode_o,
   output logic         latch_o
);
   localparam logic [W-1:0] SRC_KEEP   = SRC_MAP[W-1:0];
   localparam logic [W-1:0] GUARD_MASK = ~(W'(1) << GUARD_BIT);

   logic [W-1:0] events_q, enable_q, levels_q;
   logic         latch_q;
   logic [W-1:0] lines_m, report, rise, ev_cap, ev_nxt, en_nxt;
   logic         clr_all, latch_nxt;

   assign lines_m = lines_sync_i & SRC_KEEP;
   assign report  = lines_m ^ levels_q;
   assign rise    = lines_m & ~levels_q;
   assign mode_o  = enable_q[MODE_BIT];

   generate
      for (genvar i = 0; i < W; i++) begin : g_cap
         always_comb begin
            if (!report[i])   ev_cap[i] = events_q[i];
            else if (mode_o)  ev_cap[i] = 1'b1;
            else              ev_cap[i] = rise[i];
         end
      end
   endgenerate

   assign clr_all = ack_wr_i && mode_o && wdata_st_i[CLRALL_BIT];

   always_comb begin
      if (clr_all)       ev_nxt = '0;
      else if (ack_wr_i) ev_nxt = ev_cap & ~(wdata_st_i & GUARD_MASK);
      else               ev_nxt = ev_cap;
      en_nxt = en_wr_i ? wdata_st_i : enable_q;
      if (|(ev_nxt & en_nxt)) latch_nxt = 1'b1;
      else if (ack_wr_i)      latch_nxt = 1'b0;
      else                    latch_nxt = latch_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         events_q <= '0;
         enable_q <= '0;
         levels_q <= '0;
         latch_q  <= 1'b0;
      end else begin
         events_q <= ev_nxt;
         enable_q <= en_nxt;
         levels_q <= lines_m;
         latch_q  <= latch_nxt;
      end
   end

   assign events_o = events_q;
   assign enable_o = enable_q;
   assign levels_o = levels_q;
   assign latch_o  = latch_q;
endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port
   import irq_agg_pkg::*;
#(
   parameter int ADDR_W  = 8,
   parameter int OFF_EVT = 'h20,
   parameter int OFF_EN  = 'h24,
   parameter int OFF_ACK = 'h28,
   parameter int OFF_LVL = 'h2C
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid_i,
   input  logic              write_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [DATA_W-1:0] events_i,
   input  logic [DATA_W-1:0] enable_i,
   input  logic [DATA_W-1:0] levels_i,
   output logic              en_wr_o,
   output logic              ack_wr_o,
   output logic [DATA_W-1:0] wdata_st_o,
   output logic [DATA_W-1:0] rdata_o
);
   logic hit_evt, hit_en, hit_ack, hit_lvl, rd;
   logic [DATA_W-1:0] rd_sel, rdata_q;

   assign hit_evt = addr_i == ADDR_W'(OFF_EVT);
   assign hit_en  = addr_i == ADDR_W'(OFF_EN);
   assign hit_ack = addr_i == ADDR_W'(OFF_ACK);
   assign hit_lvl = addr_i == ADDR_W'(OFF_LVL);
   assign rd      = valid_i && !write_i;

   assign en_wr_o    = valid_i && write_i && hit_en;
   assign ack_wr_o   = valid_i && write_i && hit_ack;
   assign wdata_st_o = byte_flip(wdata_i);

   always_comb begin
      if (hit_evt)      rd_sel = events_i;
      else if (hit_en)  rd_sel = enable_i;
      else if (hit_lvl) rd_sel = levels_i;
      else              rd_sel = '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)  rdata_q <= '0;
      else if (rd) rdata_q <= byte_flip(rd_sel);
   end

   assign rdata_o = rdata_q;
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
   import irq_agg_pkg::*;
#(
   parameter int          ADDR_W      = 8,
   parameter int          SYNC_STAGES = 2,
   parameter logic [31:0] SRC_MAP     = 32'h1FFF_F3F7,
   parameter int          OFF_EVT     = 'h20,
   parameter int          OFF_EN      = 'h24,
   parameter int          OFF_ACK     = 'h28,
   parameter int          OFF_LVL     = 'h2C
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [31:0]       irq_lines_i,
   input  logic              bus_valid_i,
   input  logic              bus_write_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic [31:0]       bus_wdata_i,
   output logic [31:0]       bus_rdata_o,
   output logic              cpu_irq_o
);
   localparam int ADDR_SPAN = 1 << ADDR_W;

   generate
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("irq_aggregator: SYNC_STAGES must be 0..4");
      end
      if (OFF_EVT >= ADDR_SPAN || OFF_EN >= ADDR_SPAN ||
          OFF_ACK >= ADDR_SPAN || OFF_LVL >= ADDR_SPAN) begin : g_bad_span
         $error("irq_aggregator: register offset outside address range");
      end
      if (OFF_EVT == OFF_EN || OFF_EVT == OFF_ACK || OFF_EVT == OFF_LVL ||
          OFF_EN == OFF_ACK || OFF_EN == OFF_LVL || OFF_ACK == OFF_LVL) begin : g_bad_off
         $error("irq_aggregator: register offsets collide");
      end
   endgenerate

   logic [DATA_W-1:0] lines_sync, events_q, enable_q, levels_q, wdata_st;
   logic              en_wr, ack_wr, mode, latch_q;

   irq_line_sync #(.W(DATA_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (irq_lines_i),
      .sync_o  (lines_sync)
   );

   irq_reg_port #(
      .ADDR_W(ADDR_W), .OFF_EVT(OFF_EVT), .OFF_EN(OFF_EN),
      .OFF_ACK(OFF_ACK), .OFF_LVL(OFF_LVL)
   ) u_port (
      .clk        (clk),
      .rst_n      (rst_n),
      .valid_i    (bus_valid_i),
      .write_i    (bus_write_i),
      .addr_i     (bus_addr_i),
      .wdata_i    (bus_wdata_i),
      .events_i   (events_q),
      .enable_i   (enable_q),
      .levels_i   (levels_q),
      .en_wr_o    (en_wr),
      .ack_wr_o   (ack_wr),
      .wdata_st_o (wdata_st),
      .rdata_o    (bus_rdata_o)
   );

   irq_event_core #(.W(DATA_W), .SRC_MAP(SRC_MAP)) u_core (
      .clk          (clk),
      .rst_n        (rst_n),
      .lines_sync_i (lines_sync),
      .en_wr_i      (en_wr),
      .ack_wr_i     (ack_wr),
      .wdata_st_i   (wdata_st),
      .events_o     (events_q),
      .enable_o     (enable_q),
      .levels_o     (levels_q),
      .mode_o       (mode),
      .latch_o      (latch_q)
   );

   assign cpu_irq_o = latch_q;
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk #(
   parameter int ADDR_W  = 8,
   parameter int OFF_EVT = 'h20,
   parameter int OFF_EN  = 'h24,
   parameter int OFF_LVL = 'h2C
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_valid_i,
   input logic              bus_write_i,
   input logic [ADDR_W-1:0] bus_addr_i,
   input logic [31:0]       bus_rdata_o,
   input logic              cpu_irq_o,
   input logic [31:0]       events_q,
   input logic [31:0]       enable_q,
   input logic [31:0]       levels_q,
   input logic [31:0]       wdata_st,
   input logic              ack_wr,
   input logic              mode
);
   logic undef_rd;
   assign undef_rd = bus_valid_i && !bus_write_i &&
                     bus_addr_i != ADDR_W'(OFF_EVT) &&
                     bus_addr_i != ADDR_W'(OFF_EN) &&
                     bus_addr_i != ADDR_W'(OFF_LVL);

   // R2
   edge_only_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mode |=> ((events_q & ~$past(events_q)) & ~(levels_q & ~$past(levels_q))) == 32'h0);

   // R4
   guard_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_wr && !mode && events_q[31] |=> events_q[31] || (levels_q[31] != $past(levels_q[31])));

   // R5
   clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_wr && mode && wdata_st[31] |=> events_q == 32'h0);

   // R6
   pending_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (events_q & enable_q) != 32'h0 |-> cpu_irq_o);

   // R7
   sticky_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_irq_o && !ack_wr |=> cpu_irq_o);

   // R9
   undef_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      undef_rd |=> bus_rdata_o == 32'h0);
endmodule

bind irq_aggregator irq_aggregator_chk #(
   .ADDR_W(ADDR_W), .OFF_EVT(OFF_EVT), .OFF_EN(OFF_EN), .OFF_LVL(OFF_LVL)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_valid_i (bus_valid_i),
   .bus_write_i (bus_write_i),
   .bus_addr_i  (bus_addr_i),
   .bus_rdata_o (bus_rdata_o),
   .cpu_irq_o   (cpu_irq_o),
   .events_q    (events_q),
   .enable_q    (enable_q),
   .levels_q    (levels_q),
   .wdata_st    (wdata_st),
   .ack_wr      (ack_wr),
   .mode        (mode)
);

// File: tb/test_irq_aggregator.sv
module test_irq_aggregator;
   localparam logic [31:0] MAP = 32'h9FFF_F3F7;
   localparam logic [7:0]  A_EVT = 8'h20, A_EN = 8'h24, A_ACK = 8'h28, A_LVL = 8'h2C;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] lines = '0;
   logic        bvalid = 1'b0, bwrite = 1'b0;
   logic [7:0]  baddr = '0;
   logic [31:0] bwdata = '0;
   logic [31:0] rdata;
   logic        irq;

   int checks = 0, failures = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   irq_aggregator #(.SRC_MAP(MAP)) i_irq_aggregator (
      .clk(clk), .rst_n(rst_n), .irq_lines_i(lines),
      .bus_valid_i(bvalid), .bus_write_i(bwrite), .bus_addr_i(baddr),
      .bus_wdata_i(bwdata), .bus_rdata_o(rdata), .cpu_irq_o(irq)
   );

   function automatic logic [31:0] flip(input logic [31:0] w);
      return {w[7:0], w[15:8], w[23:16], w[31:24]};
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%08h expected=%08h at %0t", req, act, exp, $time);
      end
   endtask

   // reference model
   logic [31:0] m_s1, m_s2, m_lv, m_ev, m_en, m_rd;
   bit          m_latch, m_rd_pend;
   string       m_tag, cur_tag;

   always @(posedge clk) begin
      logic [31:0] s, ev, en, d;
      bit md, ack;
      if (!rst_n) begin
         m_s1 = 0; m_s2 = 0; m_lv = 0; m_ev = 0; m_en = 0; m_rd = 0;
         m_latch = 0; m_rd_pend = 0;
      end else begin
         s  = m_s2 & MAP;
         md = m_en[31];
         ev = m_ev;
         for (int i = 0; i < 32; i++) begin
            if (s[i] != m_lv[i]) ev[i] = md ? 1'b1 : (s[i] && !m_lv[i]);
         end
         d   = flip(bwdata);
         ack = bvalid && bwrite && baddr == A_ACK;
         en  = m_en;
         if (bvalid && bwrite && baddr == A_EN) en = d;
         if (ack) begin
            if (md && d[31]) ev = 0;
            else ev = ev & ~(d & 32'h7FFF_FFFF);
         end
         m_rd_pend = bvalid && !bwrite;
         if (m_rd_pend) begin
            m_tag = cur_tag;
            if (baddr == A_EVT)      m_rd = flip(m_ev);
            else if (baddr == A_EN)  m_rd = flip(m_en);
            else if (baddr == A_LVL) m_rd = flip(m_lv);
            else                     m_rd = 0;
         end
         if ((ev & en) != 0) m_latch = 1;
         else if (ack)       m_latch = 0;
         m_ev = ev; m_en = en; m_lv = s;
         m_s2 = m_s1; m_s1 = lines;
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(irq == m_latch, "R6 R7 request line", {31'h0, irq}, {31'h0, m_latch});
         if (m_rd_pend) chk(rdata == m_rd, m_tag, rdata, m_rd);
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] stored);
      @(negedge clk);
      bvalid = 1; bwrite = 1; baddr = a; bwdata = flip(stored);
      @(negedge clk);
      bvalid = 0; bwrite = 0;
   endtask

   task automatic rd(input logic [7:0] a, input string tag);
      @(negedge clk);
      cur_tag = tag;
      bvalid = 1; bwrite = 0; baddr = a;
      @(negedge clk);
      bvalid = 0;
   endtask

   initial begin
      #(150000 * 10);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [31:0] lcg;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk(irq == 1'b0, "R6 reset request", {31'h0, irq}, 32'h0);
      chk(rdata == 32'h0, "R8 reset read data", rdata, 32'h0);
      rd(A_EVT, "R2 events after reset");
      rd(A_EN,  "R8 enable after reset");
      rd(A_LVL, "R1 levels after reset");

      // R8: enable write / read back, edge mode, bits 0 and 12 enabled
      wr(A_EN, 32'h0000_1001);
      rd(A_EN, "R8 enable read back");
      idle(1);
      chk(rdata == flip(32'h0000_1001), "R8 port byte order", rdata, flip(32'h0000_1001));

      // R2 and R6: rise on line 0 in edge mode
      lines[0] = 1; idle(4);
      rd(A_EVT, "R2 rise sets event");
      rd(A_LVL, "R1 levels show line 0");
      chk(irq == 1'b1, "R6 request raised", {31'h0, irq}, 32'h1);
      // R2, R7: fall clears event but the request stays
      lines[0] = 0; idle(4);
      rd(A_EVT, "R2 fall clears event");
      chk(irq == 1'b1, "R7 request sticky after fall", {31'h0, irq}, 32'h1);
      wr(A_EN, 32'h0);
      idle(1);
      chk(irq == 1'b1, "R7 enable write keeps request", {31'h0, irq}, 32'h1);
      wr(A_ACK, 32'h0);
      idle(1);
      chk(irq == 1'b0, "R7 acknowledge releases", {31'h0, irq}, 32'h0);

      // R3: change mode, fall records
      wr(A_EN, 32'h8000_1001);
      lines[12] = 1; idle(4);
      wr(A_ACK, 32'h0000_1000);
      lines[12] = 0; idle(4);
      rd(A_EVT, "R3 fall records event");
      // R5: clear-all in change mode
      lines[0] = 1; idle(4);
      wr(A_ACK, 32'h8000_0000);
      rd(A_EVT, "R5 clear-all empties events");
      idle(1);
      chk(irq == 1'b0, "R5 request dropped after clear-all", {31'h0, irq}, 32'h0);
      lines[0] = 0; idle(4);

      // R4: bit 31 survives named clear in edge mode
      wr(A_EN, 32'h0000_0001);
      lines[31] = 1; idle(4);
      wr(A_ACK, 32'hFFFF_FFFF);
      rd(A_EVT, "R4 bit 31 kept by acknowledge");
      wr(A_ACK, 32'h8000_0000);
      rd(A_EVT, "R4 edge mode bit 31 not clear-all");

      // R9: levels write ignored, undefined reads zero
      wr(A_LVL, 32'hFFFF_FFFF);
      rd(A_LVL, "R9 levels write ignored");
      rd(A_ACK, "R9 acknowledge reads zero");
      rd(8'h30, "R9 undefined offset reads zero");
      rd(8'h00, "R9 undefined offset reads zero");

      // R10: unmapped positions
      lines[3] = 1; lines[10] = 1; lines[30] = 1; idle(4);
      rd(A_LVL, "R10 unmapped levels zero");
      rd(A_EVT, "R10 unmapped no events");

      // R11: acknowledge in the same cycle as a report
      wr(A_EN, 32'h0000_0020);
      lines[5] = 1;
      @(negedge clk); @(negedge clk);
      bvalid = 1; bwrite = 1; baddr = A_ACK; bwdata = flip(32'h0000_0020);
      @(negedge clk);
      bvalid = 0; bwrite = 0;
      rd(A_EVT, "R11 acknowledge wins over report");
      idle(1);
      chk(irq == 1'b0, "R11 no request after same-cycle acknowledge", {31'h0, irq}, 32'h0);
      // R11: enable write with mode in the cycle of a fall uses old edge mode
      lines[5] = 0;
      @(negedge clk); @(negedge clk);
      bvalid = 1; bwrite = 1; baddr = A_EN; bwdata = flip(32'h8000_0020);
      @(negedge clk);
      bvalid = 0; bwrite = 0;
      rd(A_EVT, "R11 old mode governs capture");

      // mixed pseudo-random traffic checked against the model
      lcg = 32'h1234_5678;
      for (int n = 0; n < 3000; n++) begin
         lcg = lcg * 32'd1664525 + 32'd1013904223;
         @(negedge clk);
         if (lcg[3:0] == 4'h0) lines = lines ^ (32'h1 << lcg[12:8]);
         if (lcg[7:4] == 4'h1) lines = lines ^ (32'h1 << lcg[20:16]);
         bvalid = 0; bwrite = 0;
         case (lcg[30:28])
            3'd0: begin bvalid = 1; bwrite = 1; baddr = A_EN;  bwdata = lcg ^ {lcg[15:0], lcg[31:16]}; end
            3'd1: begin bvalid = 1; bwrite = 1; baddr = A_ACK; bwdata = {lcg[7:0], lcg[31:8]}; end
            3'd2: begin bvalid = 1; bwrite = 0; baddr = A_EVT; cur_tag = "R2 R3 events under traffic"; end
            3'd3: begin bvalid = 1; bwrite = 0; baddr = A_LVL; cur_tag = "R1 levels under traffic"; end
            3'd4: begin bvalid = 1; bwrite = 0; baddr = A_EN;  cur_tag = "R8 enable under traffic"; end
            3'd5: begin bvalid = 1; bwrite = 1; baddr = A_LVL; bwdata = lcg; end
            default: ;
         endcase
      end
      @(negedge clk);
      bvalid = 0; bwrite = 0;
      idle(3);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule